// File: doc/BRIEF.md
# Quasi-Resonant Turn-On Trigger Controller

This block decides, cycle by cycle, when the power switch of a valley-switching flyback converter turns on and when it turns off again. Two comparator flags watch the demagnetization-sense pin: one says the pin sits above the arming level and one says it sits below the trigger level. An unsigned code reports the control-loop voltage. Two current-sense flags report that the peak-current limit or the fixed peak clamp has been reached. The block drives a single gate-enable output.

Each turn-on needs an armed falling crossing of the sense pin, and that crossing must arrive after a blanking window that starts at turn-off. The window is long at low control level and short at high control level. At light load, ringing valleys that fall inside the window are passed over, and the switching rate stays bounded. When no valid crossing arrives, an off-time starter forces a turn-on. It uses a slow period below the burst threshold and a fast period at or above it. A programmable valley delay separates the valid crossing from gate assertion. Leading-edge blanking masks both current-sense flags at the start of each on-time. An external disable input holds the gate low; it serves undervoltage lockout, faults and burst idle.

Top module: `qr_turnon_ctrl`

## Requirements
- R1: After synchronous reset `gate_o` is 0. While `disable_i` is 1, `gate_o` is 0 in the same cycle. While `disable_i` is 1 the arming and off-time are also cleared, so after release the gate stays low for exactly one starter period (R6).
- R2: A low-crossing (a 0→1 change of `sense_low_i`) is only a turn-on request if the block is armed. The block becomes armed on a 0→1 change of `sense_arm_i` while the gate is off. Turn-on clears the arming. An unarmed low-crossing is ignored.
- R3: The blanking length L is computed from `ctrl_code_i` (an unsigned code) at the clock edge where the gate turns off. For codes ≤ CODE_LO, L is BLANK_MAX. For codes ≥ CODE_HI, L is BLANK_MIN. Between the two, L = BLANK_MAX − floor((code − CODE_LO)·(BLANK_MAX − BLANK_MIN)/(CODE_HI − CODE_LO)).
- R4: Call the turn-off edge T. A low-crossing sampled at edges T+1 … T+L is discarded. The first armed low-crossing sampled at edge T+L+1 or later is accepted, so earlier ringing valleys are skipped.
- R5: If an accepted low-crossing is sampled at edge E, the gate rises at edge E+VALLEY_DLY (VALLEY_DLY ≥ 1).
- R6: If no crossing is accepted, the gate rises exactly P cycles after it fell. P is STARTER_FAST when `ctrl_code_i` ≥ CODE_BURST and STARTER_SLOW when it is below; the code is read live.
- R7: The current-sense flags have no effect during the first LEB_CYC cycles of gate-high time, so every on-time lasts at least LEB_CYC cycles unless disabled.
- R8: After the masked interval, either `cs_trip_i` or `cs_clamp_i` at 1 turns the gate off at that clock edge. The on-time is therefore the smallest m ≥ LEB_CYC for which a flag was 1 when sampled at edge G+m, where G is the gate's rising edge.
- R9: Every gate-low interval outside of disable lasts at least BLANK_MIN+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| disable_i | input | 1 | Forces the gate low and clears arming and off-time |
| sense_arm_i | input | 1 | Sense pin above the arming level |
| sense_low_i | input | 1 | Sense pin below the trigger level |
| ctrl_code_i | input | CTRL_W | Unsigned control-level code |
| cs_trip_i | input | 1 | Sensed current reached the loop's peak limit |
| cs_clamp_i | input | 1 | Sensed current reached the fixed peak clamp |
| gate_o | output | 1 | Power-switch gate enable |

## Verification
The hardest situation to reach is an armed low-crossing that lands in the final cycle of blanking, because the window boundary moves with the control code. The bench sweeps the code across both clamped ends and the interpolated range. For each code it computes L and places one crossing at the last discarded edge and one at the first accepted edge. It also places a ringing sequence that only the second valley can accept. Each case is measured as the exact gate-low time, which catches off-by-one errors in the window, the valley delay and the re-arming.

// File: rtl/qr_trig_pkg.sv
`timescale 1ns/1ps
package qr_trig_pkg;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DELAY = 2'd2,
        ST_ON    = 2'd3
    } qr_state_e;

    // Blanking length in cycles, linear between two control codes, clamped.
    function automatic int unsigned blank_cycles(
        input int unsigned code,
        input int unsigned lo,
        input int unsigned hi,
        input int unsigned bmax,
        input int unsigned bmin
    );
        if (code <= lo) return bmax;
        if (code >= hi) return bmin;
        return bmax - ((code - lo) * (bmax - bmin)) / (hi - lo);
    endfunction

    // Starter period in cycles, picked by the burst threshold.
    function automatic int unsigned starter_cycles(
        input int unsigned code,
        input int unsigned burst,
        input int unsigned slow,
        input int unsigned fast
    );
        return (code >= burst) ? fast : slow;
    endfunction

endpackage

// File: rtl/qr_edge_arm.sv
`timescale 1ns/1ps
module qr_edge_arm (
    input  logic clk,
    input  logic rst,
    input  logic sense_arm_i,
    input  logic sense_low_i,
    input  logic clear_i,
    output logic low_cross_o,
    output logic armed_o
);
    logic arm_q;
    logic low_q;
    logic arm_rise;

    assign arm_rise    = sense_arm_i & ~arm_q;
    assign low_cross_o = sense_low_i & ~low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q   <= 1'b0;
            low_q   <= 1'b0;
            armed_o <= 1'b0;
        end else begin
            arm_q <= sense_arm_i;
            low_q <= sense_low_i;
            if (clear_i)
                armed_o <= 1'b0;
            else if (arm_rise)
                armed_o <= 1'b1;
        end
    end
endmodule

// File: rtl/qr_off_timer.sv
`timescale 1ns/1ps
module qr_off_timer
    import qr_trig_pkg::*;
#(
    parameter int CTRL_W       = 8,
    parameter int CODE_LO      = 90,
    parameter int CODE_HI      = 130,
    parameter int CODE_BURST   = 100,
    parameter int BLANK_MAX    = 7500,
    parameter int BLANK_MIN    = 1500,
    parameter int STARTER_SLOW = 125000,
    parameter int STARTER_FAST = 31250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              load_i,
    input  logic              blank_run_i,
    input  logic              starter_clr_i,
    output logic              blank_done_o,
    output logic              starter_due_o
);
    localparam int BW   = $clog2(BLANK_MAX + 1);
    localparam int SMAX = (STARTER_SLOW > STARTER_FAST) ? STARTER_SLOW : STARTER_FAST;
    localparam int SW   = $clog2(SMAX + 1);

    logic [BW-1:0] bcnt;
    logic [SW-1:0] scnt;
    int unsigned   blank_len;
    int unsigned   period;

    always_comb begin
        blank_len = blank_cycles(32'(ctrl_i), CODE_LO, CODE_HI, BLANK_MAX, BLANK_MIN);
        period    = starter_cycles(32'(ctrl_i), CODE_BURST, STARTER_SLOW, STARTER_FAST);
    end

    always_ff @(posedge clk) begin
        if (rst)
            bcnt <= '0;
        else if (load_i)
            bcnt <= BW'(blank_len - 1);
        else if (blank_run_i && bcnt != '0)
            bcnt <= bcnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || starter_clr_i)
            scnt <= '0;
        else if (scnt != SW'(SMAX - 1))
            scnt <= scnt + 1'b1;
    end

    assign blank_done_o  = (bcnt == '0);
    assign starter_due_o = (32'(scnt) >= period - 1);
endmodule

// File: rtl/qr_leb.sv
`timescale 1ns/1ps
module qr_leb #(
    parameter int LEB_CYC = 62
) (
    input  logic clk,
    input  logic rst,
    input  logic on_i,
    output logic done_o
);
    localparam int LW = $clog2(LEB_CYC + 1);

    logic [LW-1:0] lcnt;

    assign done_o = (lcnt >= LW'(LEB_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !on_i)
            lcnt <= '0;
        else if (!done_o)
            lcnt <= lcnt + 1'b1;
    end
endmodule

// File: rtl/qr_turnon_ctrl.sv
`timescale 1ns/1ps
module qr_turnon_ctrl
    import qr_trig_pkg::*;
#(
    parameter int CTRL_W       = 8,
    parameter int CODE_LO      = 90,
    parameter int CODE_HI      = 130,
    parameter int CODE_BURST   = 100,
    parameter int BLANK_MAX    = 7500,
    parameter int BLANK_MIN    = 1500,
    parameter int STARTER_SLOW = 125000,
    parameter int STARTER_FAST = 31250,
    parameter int LEB_CYC      = 62,
    parameter int VALLEY_DLY   = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disable_i,
    input  logic              sense_arm_i,
    input  logic              sense_low_i,
    input  logic [CTRL_W-1:0] ctrl_code_i,
    input  logic              cs_trip_i,
    input  logic              cs_clamp_i,
    output logic              gate_o
);
    localparam int DW = $clog2(VALLEY_DLY + 1);

    qr_state_e     state_q, state_d;
    logic [DW-1:0] dcnt;
    logic          low_cross, armed;
    logic          blank_done, starter_due, leb_done;
    logic          load_blank, load_dly;

    qr_edge_arm u_arm (
        .clk         (clk),
        .rst         (rst),
        .sense_arm_i (sense_arm_i),
        .sense_low_i (sense_low_i),
        .clear_i     (disable_i || state_q == ST_DELAY || state_q == ST_ON),
        .low_cross_o (low_cross),
        .armed_o     (armed)
    );

    qr_off_timer #(
        .CTRL_W       (CTRL_W),
        .CODE_LO      (CODE_LO),
        .CODE_HI      (CODE_HI),
        .CODE_BURST   (CODE_BURST),
        .BLANK_MAX    (BLANK_MAX),
        .BLANK_MIN    (BLANK_MIN),
        .STARTER_SLOW (STARTER_SLOW),
        .STARTER_FAST (STARTER_FAST)
    ) u_off (
        .clk           (clk),
        .rst           (rst),
        .ctrl_i        (ctrl_code_i),
        .load_i        (load_blank),
        .blank_run_i   (state_q == ST_BLANK),
        .starter_clr_i (disable_i || state_q == ST_DELAY || state_q == ST_ON),
        .blank_done_o  (blank_done),
        .starter_due_o (starter_due)
    );

    qr_leb #(.LEB_CYC(LEB_CYC)) u_leb (
        .clk    (clk),
        .rst    (rst),
        .on_i   (state_q == ST_ON),
        .done_o (leb_done)
    );

    always_comb begin
        state_d    = state_q;
        load_blank = 1'b0;
        load_dly   = 1'b0;
        if (disable_i) begin
            state_d = ST_WAIT;
        end else begin
            unique case (state_q)
                ST_BLANK: if (blank_done) state_d = ST_WAIT;
                ST_WAIT: begin
                    if (armed && low_cross) begin
                        state_d  = ST_DELAY;
                        load_dly = 1'b1;
                    end else if (starter_due) begin
                        state_d = ST_ON;
                    end
                end
                ST_DELAY: if (dcnt == '0) state_d = ST_ON;
                ST_ON: begin
                    if (leb_done && (cs_trip_i || cs_clamp_i)) begin
                        state_d    = ST_BLANK;
                        load_blank = 1'b1;
                    end
                end
                default: state_d = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            dcnt    <= '0;
        end else begin
            state_q <= state_d;
            if (load_dly)
                dcnt <= DW'(VALLEY_DLY - 1);
            else if (state_q == ST_DELAY && dcnt != '0)
                dcnt <= dcnt - 1'b1;
        end
    end

    assign gate_o = (state_q == ST_ON) && !disable_i;
endmodule

// File: rtl/qr_turnon_chk.sv
`timescale 1ns/1ps
module qr_turnon_chk
    import qr_trig_pkg::*;
#(
    parameter int LEB_CYC   = 62,
    parameter int BLANK_MIN = 1500
) (
    input logic      clk,
    input logic      rst,
    input logic      disable_i,
    input logic      gate_o,
    input qr_state_e state_q,
    input logic      armed
);
    int unsigned hi_cnt;
    int unsigned lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= 0;
            lo_cnt <= 0;
        end else begin
            hi_cnt <= gate_o ? hi_cnt + 1 : 0;
            lo_cnt <= gate_o ? 0 : lo_cnt + 1;
        end
    end

    assert_disable_gate_R1: assert property (@(posedge clk) disable iff (rst)
        disable_i |=> !gate_o);

    assert_armed_request_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DELAY && $past(state_q) != ST_DELAY) |-> $past(armed));

    assert_delay_after_window_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DELAY && $past(state_q) != ST_DELAY) |-> $past(state_q) == ST_WAIT);

    assert_min_on_time_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate_o) && !disable_i && !$past(disable_i)) |-> hi_cnt >= LEB_CYC);

    assert_min_off_time_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_o) |-> lo_cnt >= BLANK_MIN + 1);
endmodule

bind qr_turnon_ctrl qr_turnon_chk #(
    .LEB_CYC   (LEB_CYC),
    .BLANK_MIN (BLANK_MIN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .disable_i (disable_i),
    .gate_o    (gate_o),
    .state_q   (state_q),
    .armed     (armed)
);

// File: tb/qr_turnon_ctrl_bench.sv
`timescale 1ns/1ps
module qr_turnon_ctrl_bench;
    localparam int CTRL_W = 8;
    localparam int LO     = 90;
    localparam int HI     = 130;
    localparam int BURST  = 100;
    localparam int BMAX   = 30;
    localparam int BMIN   = 6;
    localparam int PSLOW  = 200;
    localparam int PFAST  = 100;
    localparam int LEB    = 4;
    localparam int VD     = 2;

    logic clk = 1'b0;
    logic rst, dis, sarm, slow_s, cs, clamp, gate;
    logic [CTRL_W-1:0] ctrl;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    qr_turnon_ctrl #(
        .CTRL_W(CTRL_W), .CODE_LO(LO), .CODE_HI(HI), .CODE_BURST(BURST),
        .BLANK_MAX(BMAX), .BLANK_MIN(BMIN), .STARTER_SLOW(PSLOW),
        .STARTER_FAST(PFAST), .LEB_CYC(LEB), .VALLEY_DLY(VD)
    ) u_qr_turnon_ctrl (
        .clk(clk), .rst(rst), .disable_i(dis), .sense_arm_i(sarm),
        .sense_low_i(slow_s), .ctrl_code_i(ctrl), .cs_trip_i(cs),
        .cs_clamp_i(clamp), .gate_o(gate)
    );

    function automatic int exp_blank(input int c);
        if (c <= LO) return BMAX;
        if (c >= HI) return BMIN;
        return BMAX - ((c - LO) * (BMAX - BMIN)) / (HI - LO);
    endfunction

    function automatic int exp_on(input int p, input int k);
        for (int m = LEB; m < 1000; m++)
            if ((m - 1) < p || (m - 1) >= k) return m;
        return -1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts low samples from the current negedge, driving sense pulses by offset j.
    task automatic off_loop(input int a1, input int t1, input int a2, input int t2,
                            output int lows);
        int j = 0;
        lows = 0;
        while (gate == 1'b0 && lows < 2000) begin
            sarm   = (a1 >= 0 && (j == a1 || j == a1 + 1)) ||
                     (a2 >= 0 && (j == a2 || j == a2 + 1));
            slow_s = (t1 >= 0 && j == t1) || (t2 >= 0 && j == t2);
            lows++;
            @(negedge clk);
            j++;
        end
        sarm   = 1'b0;
        slow_s = 1'b0;
    endtask

    task automatic run_off(input int a1, input int t1, input int a2, input int t2,
                           output int lows);
        int g = 0;
        while (gate == 1'b0 && g < 2000) begin @(negedge clk); g++; end
        while (gate == 1'b1 && g < 4000) begin @(negedge clk); g++; end
        off_loop(a1, t1, a2, t2, lows);
    endtask

    task automatic run_on(input int p, input int k, input bit use_clamp, output int highs);
        int g = 0;
        int j = 0;
        while (gate == 1'b1 && g < 2000) begin @(negedge clk); g++; end
        while (gate == 1'b0 && g < 4000) begin @(negedge clk); g++; end
        highs = 0;
        while (gate == 1'b1 && highs < 2000) begin
            if (use_clamp) begin clamp = (j < p) || (j >= k); cs = 1'b0; end
            else           begin cs    = (j < p) || (j >= k); clamp = 1'b0; end
            highs++;
            @(negedge clk);
            j++;
        end
        cs    = 1'b1;
        clamp = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int lows, highs, hcount, l;
        rst = 1'b1; dis = 1'b1; sarm = 1'b0; slow_s = 1'b0;
        cs = 1'b1; clamp = 1'b0; ctrl = 8'd95;
        repeat (3) @(negedge clk);
        check("R1 reset gate", int'(gate), 0);
        rst = 1'b0;
        hcount = 0;
        repeat (10) begin @(negedge clk); if (gate) hcount++; end
        check("R1 held by disable", hcount, 0);

        // R6: release disable, slow starter below burst code
        dis = 1'b0;
        off_loop(-1, -1, -1, -1, lows);
        check("R6 slow starter after release", lows, PSLOW);
        highs = 0;
        while (gate == 1'b1 && highs < 100) begin highs++; @(negedge clk); end
        check("R8 on-time with flag held", highs, LEB);

        run_off(-1, -1, -1, -1, lows);
        check("R6 slow starter", lows, PSLOW);
        ctrl = 8'd99;
        run_off(-1, -1, -1, -1, lows);
        check("R6 code just below burst", lows, PSLOW);
        ctrl = 8'd100;
        run_off(-1, -1, -1, -1, lows);
        check("R6 code at burst threshold", lows, PFAST);

        // R2: unarmed crossing after the window is ignored
        ctrl = 8'd95;
        run_off(-1, exp_blank(95) + 2, -1, -1, lows);
        check("R2 unarmed crossing ignored", lows, PSLOW);

        // R3 R4 R5: sweep control codes across the window boundary
        for (int c = 80; c <= 140; c += 5) begin
            ctrl = CTRL_W'(c);
            l = exp_blank(c);
            run_off(0, l, -1, -1, lows);
            check($sformatf("R3 R5 first accepted edge code %0d", c), lows, l + 1 + VD);
            run_off(0, l - 1, l + 1, l + 3, lows);
            check($sformatf("R4 valley skip code %0d", c), lows, l + 4 + VD);
        end

        // R7 R8: leading-edge blanking of both flags
        ctrl = 8'd120;
        run_on(0, 0, 1'b0, highs);
        check("R8 trip held", highs, exp_on(0, 0));
        run_on(0, LEB + 3, 1'b0, highs);
        check("R8 late trip", highs, exp_on(0, LEB + 3));
        run_on(LEB - 1, LEB + 5, 1'b0, highs);
        check("R7 trip inside blanking ignored", highs, exp_on(LEB - 1, LEB + 5));
        run_on(0, 0, 1'b1, highs);
        check("R8 clamp held", highs, exp_on(0, 0));
        run_on(LEB - 1, LEB + 2, 1'b1, highs);
        check("R7 clamp inside blanking ignored", highs, exp_on(LEB - 1, LEB + 2));

        // R1: disable during on-time
        begin
            int g = 0;
            while (gate == 1'b0 && g < 2000) begin @(negedge clk); g++; end
        end
        dis = 1'b1;
        #1;
        check("R1 disable drops gate at once", int'(gate), 0);
        hcount = 0;
        repeat (5) begin @(negedge clk); if (gate) hcount++; end
        check("R1 gate stays low while disabled", hcount, 0);
        dis = 1'b0;
        off_loop(-1, -1, -1, -1, lows);
        check("R1 R6 restart after disable", lows, PFAST);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule